// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Polarity Select

This block moves one 8-bit character at a time over a three-wire synchronous link and drives the link's transfer clock itself. Software-side logic loads a byte into a transmit holding buffer. When the unit is in synchronous mode and transmission is allowed, the byte moves into the transmit register and goes out on the data pin. During the same transfer the unit samples the receive pin and assembles an incoming byte. A receive-complete flag reports that the incoming byte is ready, and an overrun flag reports that a byte was lost.

A single polarity control selects two things together: which transfer-clock edge launches data and which edge samples it, and the level the clock pin holds between transfers. Further controls select the bit order and an optional logic inversion of both data directions. A divider value sets the length of each clock half-period in system clocks. Leaving synchronous mode stops any transfer in progress and empties every buffer, shift register and flag. This is the way the link is recovered after a communication error.

Top module: `ssx_top`

## Requirements
- R1: With `clk_pol_i`=0, `txd_o` changes only together with a high-to-low step of `sclk_o`, and `rxd_i` is taken in at the low-to-high step.
- R2: With `clk_pol_i`=1, `txd_o` changes together with a low-to-high step of `sclk_o`, and `rxd_i` is taken in at the high-to-low step.
- R3: With no transfer running, `sclk_o` equals the inverse of `clk_pol_i` (high for 0, low for 1) and `txd_o` is 1.
- R4: With `msb_first_i`=0, a frame is 8 bits and goes out from bit 0 up to bit 7. The first bit received is stored in bit 0 of the receive byte.
- R5: With `msb_first_i`=1, bit 7 goes out first and bit 0 goes out last. Received bits are stored starting at bit 7.
- R6: With `data_inv_i`=1, every transmitted bit is the complement of the buffer bit and every received bit is complemented before it is stored. With 0, neither is complemented.
- R7: Each half-period of `sclk_o` during a transfer lasts `half_div_i`+1 system clocks.
- R8: A transfer starts only when `mode_i`=3'b001, `tx_en_i`=1 and the transmit buffer holds a byte. At the start the byte moves to the transmit register and `tb_empty_o` rises on the next cycle.
- R9: On the eighth sample edge the assembled byte appears on `rb_data_o` and `rx_done_o` goes to 1. A one-cycle `rb_rd_i` pulse clears `rx_done_o`.
- R10: If a byte completes while `rx_done_o` is still 1, `overrun_o` goes to 1 and stays at 1 until the mode is changed away from 3'b001.
- R11: Any `mode_i` other than 3'b001 aborts the transfer. It empties the transmit buffer and the transmit register, clears the receive byte, the receive shift state, `rx_done_o` and `overrun_o`, and ignores writes. Returning to 3'b001 starts nothing until a new byte is written.
- R12: With `rx_en_i`=0 a transfer still transmits, but `rb_data_o` and `rx_done_o` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Mode select: 3'b001 synchronous, any other value disabled and flushing |
| tx_en_i | input | 1 | Allows a transfer to start |
| rx_en_i | input | 1 | Allows received bits to be stored |
| clk_pol_i | input | 1 | Transfer-clock polarity and idle level |
| msb_first_i | input | 1 | Bit order: 0 bit 0 first, 1 bit 7 first |
| data_inv_i | input | 1 | Complements transmitted and received bits |
| half_div_i | input | DIV_W | Half-period length minus one, in system clocks |
| tb_wr_i | input | 1 | Writes `tb_data_i` into the transmit buffer |
| tb_data_i | input | DATA_W | Transmit buffer write data |
| rb_rd_i | input | 1 | Read strobe, clears the receive-complete flag |
| rb_data_o | output | DATA_W | Receive buffer |
| tb_empty_o | output | 1 | Transmit buffer holds no byte |
| rx_done_o | output | 1 | Receive-complete flag |
| overrun_o | output | 1 | Overrun flag |
| sclk_o | output | 1 | Transfer clock pin |
| txd_o | output | 1 | Transmit data pin |
| rxd_i | input | 1 | Receive data pin |

## Verification
The edge and idle-level assertions assume that the polarity, bit-order, inversion, divider and receive-enable controls stay constant while a transfer runs. They also assume that `rxd_i` changes only in the launch half of each bit. The stimulus changes these controls only between frames, after the clock has been idle for at least a cycle. It drives the receive pin at the start of each launch half-period, like an external slave. The only control changed during a transfer is the mode, which is allowed to abort it.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [2:0] {
    MODE_OFF  = 3'b000,
    MODE_SYNC = 3'b001
  } ssx_mode_e;
endpackage

// File: rtl/ssx_baud.sv
module ssx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R7: a divider above zero never yields two ticks back to back
  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && half_div != '0 && $stable(half_div)) |=> !tick);
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic              shift,
  input  logic              stop,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              inv,
  output logic              tb_full,
  output logic              txd
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] xreg_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      hold_q  <= '0;
      xreg_q  <= '0;
      tb_full <= 1'b0;
      txd     <= 1'b1;
    end else begin
      if (load) begin
        xreg_q <= hold_q;
        txd    <= hold_q[bit_idx] ^ inv;
      end else if (shift) begin
        txd    <= xreg_q[bit_idx] ^ inv;
      end else if (stop) begin
        txd    <= 1'b1;
      end
      if (wr) begin
        hold_q  <= wdata;
        tb_full <= 1'b1;
      end else if (load) begin
        tb_full <= 1'b0;
      end
    end
  end

  // R11: leaving synchronous mode empties the buffer and parks the pin high
  p_flush_tx_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!active) |-> (!tb_full && txd));
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rx_en,
  input  logic              samp,
  input  logic              last,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              rxd,
  input  logic              inv,
  input  logic              rd,
  output logic [DATA_W-1:0] rb_data,
  output logic              done,
  output logic              ovr
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] merged;
  logic              finish;

  always_comb begin
    merged          = sh_q;
    merged[bit_idx] = rxd ^ inv;
  end

  assign finish = samp && last && rx_en;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sh_q    <= '0;
      rb_data <= '0;
      done    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (!rx_en || finish) sh_q <= '0;
      else if (samp)        sh_q <= merged;
      if (finish) begin
        rb_data <= merged;
        done    <= 1'b1;
        ovr     <= ovr | done;
      end else if (rd) begin
        done <= 1'b0;
      end
    end
  end

  // R10: overrun only rises when an unread byte was already waiting
  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(done));
  // R9: completion only follows the last sample with reception allowed
  p_done_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(samp && last && rx_en));
endmodule

// File: rtl/ssx_top.sv
module ssx_top #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              clk_pol_i,
  input  logic              msb_first_i,
  input  logic              data_inv_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              tb_wr_i,
  input  logic [DATA_W-1:0] tb_data_i,
  input  logic              rb_rd_i,
  output logic [DATA_W-1:0] rb_data_o,
  output logic              tb_empty_o,
  output logic              rx_done_o,
  output logic              overrun_o,
  output logic              sclk_o,
  output logic              txd_o,
  input  logic              rxd_i
);
  import ssx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic             active, tb_full, tick;
  logic             busy_q, half_q;
  logic [IDX_W-1:0] cnt_q, nxt_cnt;
  logic             start, samp, adv, last, shift, stop;
  logic [IDX_W-1:0] cur_idx, nxt_idx, first_idx, launch_idx;

  assign active  = (mode_i == MODE_SYNC);
  assign start   = active && tx_en_i && tb_full && !busy_q;
  assign samp    = tick && !half_q;
  assign adv     = tick && half_q;
  assign last    = (cnt_q == LAST_IDX);
  assign shift   = adv && !last;
  assign stop    = adv && last;
  assign nxt_cnt = cnt_q + 1'b1;

  assign cur_idx    = msb_first_i ? (LAST_IDX - cnt_q)   : cnt_q;
  assign nxt_idx    = msb_first_i ? (LAST_IDX - nxt_cnt) : nxt_cnt;
  assign first_idx  = msb_first_i ? LAST_IDX : '0;
  assign launch_idx = start ? first_idx : nxt_idx;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      cnt_q  <= '0;
      sclk_o <= !clk_pol_i;
    end else if (start) begin
      busy_q <= 1'b1;
      half_q <= 1'b0;
      cnt_q  <= '0;
      sclk_o <= clk_pol_i;
    end else if (samp) begin
      half_q <= 1'b1;
      sclk_o <= !clk_pol_i;
    end else if (stop) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
    end else if (shift) begin
      half_q <= 1'b0;
      cnt_q  <= nxt_cnt;
      sclk_o <= clk_pol_i;
    end else if (!busy_q) begin
      sclk_o <= !clk_pol_i;
    end
  end

  assign tb_empty_o = !tb_full;

  ssx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_q),
    .half_div (half_div_i),
    .tick     (tick)
  );

  ssx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .wr      (tb_wr_i),
    .wdata   (tb_data_i),
    .load    (start),
    .shift   (shift),
    .stop    (stop),
    .bit_idx (launch_idx),
    .inv     (data_inv_i),
    .tb_full (tb_full),
    .txd     (txd_o)
  );

  ssx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .rx_en   (rx_en_i),
    .samp    (samp),
    .last    (last),
    .bit_idx (cur_idx),
    .rxd     (rxd_i),
    .inv     (data_inv_i),
    .rd      (rb_rd_i),
    .rb_data (rb_data_o),
    .done    (rx_done_o),
    .ovr     (overrun_o)
  );

  // R1 and R2: mid-frame data steps coincide with the clock moving to the polarity level
  p_launch_edge_r1: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && $stable(clk_pol_i) && txd_o != $past(txd_o))
      |-> (sclk_o == clk_pol_i));
  // R3: an idle clock pin rests opposite to the polarity control
  p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(busy_q) && $stable(clk_pol_i)) |-> (sclk_o == !clk_pol_i));
  // R8: a frame begins only from a loaded buffer with transmission allowed
  p_start_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(tb_full && tx_en_i && active));
endmodule

// File: tb/ssx_top_bench.sv
module ssx_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       tx_en = 1'b0, rx_en = 1'b0, pol = 1'b0, msb = 1'b0, inv = 1'b0;
  logic [3:0] hdiv = 4'd0;
  logic       tb_wr = 1'b0, rb_rd = 1'b0, rxd = 1'b0;
  logic [7:0] tb_data = 8'h00;
  logic [7:0] rb_data;
  logic       tb_empty, rx_done, overrun, sclk, txd;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ssx_top #(.DATA_W(8), .DIV_W(4)) u_ssx_top (
    .clk(clk), .rst(rst), .mode_i(mode), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .clk_pol_i(pol), .msb_first_i(msb), .data_inv_i(inv), .half_div_i(hdiv),
    .tb_wr_i(tb_wr), .tb_data_i(tb_data), .rb_rd_i(rb_rd), .rb_data_o(rb_data),
    .tb_empty_o(tb_empty), .rx_done_o(rx_done), .overrun_o(overrun),
    .sclk_o(sclk), .txd_o(txd), .rxd_i(rxd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string order_tag();
    return inv ? "R6" : (msb ? "R5" : "R4");
  endfunction

  // one full frame: tx byte out, slave byte sx driven on the receive pin
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sx, input bit want_rx);
    int h = int'(hdiv) + 1;
    @(negedge clk); tb_wr = 1'b1; tb_data = tx;
    @(negedge clk); tb_wr = 1'b0;
    chk("R3 idle clock before start", sclk, !pol);
    @(negedge clk);
    chk("R8 buffer empties at start", tb_empty, 1);
    for (int j = 0; j < 8; j++) begin
      int idx = msb ? 7 - j : j;
      rxd = sx[idx] ^ inv;
      for (int c = 0; c < h; c++) begin
        chk(c == 0 ? (pol ? "R2 launch level" : "R1 launch level") : "R7 launch half length",
            sclk, pol);
        chk(order_tag(), txd, tx[idx] ^ inv);
        @(negedge clk);
      end
      for (int c = 0; c < h; c++) begin
        chk(c == 0 ? (pol ? "R2 sample level" : "R1 sample level") : "R7 sample half length",
            sclk, !pol);
        @(negedge clk);
      end
    end
    chk("R3 idle clock after frame", sclk, !pol);
    chk("R3 idle data high", txd, 1);
    if (want_rx) begin
      chk("R9 done flag", rx_done, 1);
      chk(order_tag(), rb_data, sx);
    end
  endtask

  task automatic read_rb();
    @(negedge clk); rb_rd = 1'b1;
    @(negedge clk); rb_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset tb_empty", tb_empty, 1);
    chk("R11 reset rx_done", rx_done, 0);
    chk("R11 reset overrun", overrun, 0);
    chk("R11 reset rb", rb_data, 0);
    chk("R3 reset sclk", sclk, 1);
    chk("R3 reset txd", txd, 1);

    mode = 3'b001; tx_en = 1'b1; rx_en = 1'b1;
    for (int cfg = 0; cfg < 24; cfg++) begin
      @(negedge clk);
      pol = cfg[0]; msb = cfg[1]; inv = cfg[2];
      hdiv = 4'(cfg / 8);
      xfer(8'h35 + 8'(cfg * 29), 8'hC6 ^ 8'(cfg * 53), 1'b1);
      read_rb();
      chk("R9 read clears done", rx_done, 0);
    end

    // overrun
    pol = 1'b0; msb = 1'b0; inv = 1'b0; hdiv = 4'd1;
    xfer(8'h0F, 8'h81, 1'b1);
    chk("R10 no overrun yet", overrun, 0);
    xfer(8'hF0, 8'h7E, 1'b1);
    chk("R10 overrun raised", overrun, 1);
    read_rb();
    chk("R10 overrun sticky", overrun, 1);

    // mode disable flushes
    @(negedge clk); mode = 3'b000;
    @(negedge clk);
    chk("R11 overrun cleared", overrun, 0);
    chk("R11 done cleared", rx_done, 0);
    chk("R11 rb cleared", rb_data, 0);
    tb_wr = 1'b1; tb_data = 8'h5A;
    @(negedge clk); tb_wr = 1'b0;
    chk("R11 write ignored", tb_empty, 1);
    mode = 3'b001;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 no start after re-enable", sclk, !pol);
    end

    // abort in mid frame
    hdiv = 4'd2;
    @(negedge clk); tb_wr = 1'b1; tb_data = 8'h3C;
    @(negedge clk); tb_wr = 1'b0;
    repeat (7) @(negedge clk);
    mode = 3'b000;
    @(negedge clk);
    chk("R11 abort clock idle", sclk, !pol);
    chk("R11 abort data high", txd, 1);
    chk("R11 abort buffer empty", tb_empty, 1);
    mode = 3'b001;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 nothing restarts", sclk, !pol);
    end
    xfer(8'hA6, 8'h19, 1'b1);
    read_rb();

    // start gating on transmit enable
    pol = 1'b1; hdiv = 4'd0;
    @(negedge clk); tx_en = 1'b0; tb_wr = 1'b1; tb_data = 8'h96;
    @(negedge clk); tb_wr = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 held without enable", sclk, !pol);
    end
    chk("R8 buffer still full", tb_empty, 0);
    tx_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 started", tb_empty, 1);
    repeat (20) @(negedge clk);
    chk("R8 frame done", rx_done, 1);
    read_rb();

    // reception disabled
    @(negedge clk); mode = 3'b000;
    @(negedge clk); mode = 3'b001; rx_en = 1'b0;
    xfer(8'h71, 8'hE2, 1'b0);
    chk("R12 done untouched", rx_done, 0);
    chk("R12 rb untouched", rb_data, 0);
    rx_en = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule